// File: doc/BRIEF.md
# Add/Subtract Unit with Relational Compare

This block is a purely combinational two's-complement adder/subtractor of parameterised width. A single control input picks between sum and difference. Subtraction reuses the same ripple chain: the second operand is inverted bit by bit and the control bit is fed in as the chain's initial carry, so the block forms `A + ~B + 1`. Alongside the result it reports four condition flags: zero, negative, carry and signed overflow.

A compare stage turns those four flags into one relational outcome chosen by a 4-bit condition code. Six codes cover signed relations and four cover unsigned ones. To compare two operands, the caller sets the subtract control and reads the compare output. With subtraction active, a carry of 1 means no borrow occurred. The compare stage always decodes the flags that are present on the outputs. With addition selected, it therefore decodes the flags of the sum.

Top module: `addsub_cmp`

## Requirements
- R1: With `sub_en` = 0, `sum_o` equals `(op_a + op_b) mod 2^W`.
- R2: With `sub_en` = 1, `sum_o` equals `(op_a - op_b) mod 2^W`. The block forms this as `op_a + ~op_b + 1`.
- R3: `flag_z` is 1 exactly when every bit of `sum_o` is 0.
- R4: `flag_n` equals the most significant bit of `sum_o`.
- R5: `flag_c` is the carry out of the top bit of `op_a + (op_b XOR {W{sub_en}}) + sub_en`. With subtraction active, it is 1 exactly when `op_a >= op_b` as unsigned numbers.
- R6: `flag_v` is 1 exactly when the signed result of the selected operation falls outside the range -2^(W-1) to 2^(W-1)-1.
- R7: With `sub_en` = 1, signed codes on `cc_sel` give `cmp_o` as follows: 0 = equal, 1 = not equal, 2 = A<B, 3 = A<=B, 4 = A>B and 5 = A>=B. A and B are read as signed values.
- R8: With `sub_en` = 1, unsigned codes on `cc_sel` give `cmp_o` as follows: 6 = A<B, 7 = A<=B, 8 = A>B and 9 = A>=B. A and B are read as unsigned values.
- R9: Codes 10 to 15 on `cc_sel` drive `cmp_o` to 0 for any operands.
- R10: A carry that enters at bit 0 travels through every position. All-ones plus one gives `sum_o` = 0, `flag_c` = 1, `flag_z` = 1 and `flag_v` = 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_a | input | W | First operand |
| op_b | input | W | Second operand |
| sub_en | input | 1 | 1 selects subtract, 0 selects add |
| cc_sel | input | 4 | Relational condition code |
| sum_o | output | W | Sum or difference |
| flag_z | output | 1 | Result is zero |
| flag_n | output | 1 | Result sign bit |
| flag_c | output | 1 | Carry out of the top bit |
| flag_v | output | 1 | Signed overflow |
| cmp_o | output | 1 | Outcome of the selected relation |

## Verification
Operand pairs are built from the extreme values: zero, one, minus one, the largest positive value and the most negative value. These pairs are tried in both add and subtract mode. The mixed-sign and same-sign pairs show whether overflow is taken from the sign bits of the effective operands or from the raw operands. The carry-chain case checks that a carry travels the full width. The relational sweep runs every code against equal, signed-ordered and unsigned-ordered pairs. Where the signed and unsigned orderings disagree, a swap of the signed and unsigned decodes becomes visible. Random operands then cover the general behaviour of the adder.

// File: rtl/addsub_pkg.sv
package addsub_pkg;

    // Relational condition codes decoded from the flags of A-B
    localparam logic [3:0] CC_EQ  = 4'd0;
    localparam logic [3:0] CC_NE  = 4'd1;
    localparam logic [3:0] CC_LT  = 4'd2;
    localparam logic [3:0] CC_LE  = 4'd3;
    localparam logic [3:0] CC_GT  = 4'd4;
    localparam logic [3:0] CC_GE  = 4'd5;
    localparam logic [3:0] CC_LTU = 4'd6;
    localparam logic [3:0] CC_LEU = 4'd7;
    localparam logic [3:0] CC_GTU = 4'd8;
    localparam logic [3:0] CC_GEU = 4'd9;

    typedef struct packed {
        logic z;
        logic n;
        logic c;
        logic v;
    } flags_t;

    // One full-adder column
    function automatic logic [1:0] fa_col(input logic a, input logic b, input logic ci);
        logic p;
        p = a ^ b;
        return {(ci & p) | (a & b), ci ^ p};
    endfunction

    // Signed "less than" after A-B
    function automatic logic sgn_lt(input flags_t f);
        return f.n ^ f.v;
    endfunction

    // Unsigned "less than" after A-B: a borrow means no carry out
    function automatic logic uns_lt(input flags_t f);
        return ~f.c;
    endfunction

    function automatic logic cc_hit(input logic [3:0] sel, input flags_t f);
        logic hit;
        case (sel)
            CC_EQ:   hit = f.z;
            CC_NE:   hit = ~f.z;
            CC_LT:   hit = sgn_lt(f);
            CC_LE:   hit = f.z | sgn_lt(f);
            CC_GT:   hit = ~(f.z | sgn_lt(f));
            CC_GE:   hit = ~sgn_lt(f);
            CC_LTU:  hit = uns_lt(f);
            CC_LEU:  hit = uns_lt(f) | f.z;
            CC_GTU:  hit = ~uns_lt(f) & ~f.z;
            CC_GEU:  hit = ~uns_lt(f);
            default: hit = 1'b0;
        endcase
        return hit;
    endfunction

endpackage

// File: rtl/addsub_ripple.sv
module addsub_ripple
    import addsub_pkg::*;
#(
    parameter int W = 8
) (
    input  logic [W-1:0] a_in,
    input  logic [W-1:0] b_in,
    input  logic         cin,
    output logic [W-1:0] sum,
    output logic [W:0]   cy
);

    assign cy[0] = cin;

    for (genvar i = 0; i < W; i++) begin : g_col
        logic [1:0] col;
        assign col       = fa_col(a_in[i], b_in[i], cy[i]);
        assign sum[i]    = col[0];
        assign cy[i+1]   = col[1];
    end

endmodule

// File: rtl/addsub_flags.sv
module addsub_flags
    import addsub_pkg::*;
#(
    parameter int W = 8
) (
    input  logic [W-1:0] sum,
    input  logic         c_msb_in,
    input  logic         c_out,
    output flags_t       flg
);

    always_comb begin
        flg.z = ~|sum;
        flg.n = sum[W-1];
        flg.c = c_out;
        flg.v = c_out ^ c_msb_in;
    end

endmodule

// File: rtl/addsub_cond.sv
module addsub_cond
    import addsub_pkg::*;
(
    input  flags_t     flg,
    input  logic [3:0] sel,
    output logic       hit
);

    assign hit = cc_hit(sel, flg);

endmodule

// File: rtl/addsub_cmp.sv
module addsub_cmp
    import addsub_pkg::*;
#(
    parameter int W = 8
) (
    input  logic [W-1:0] op_a,
    input  logic [W-1:0] op_b,
    input  logic         sub_en,
    input  logic [3:0]   cc_sel,
    output logic [W-1:0] sum_o,
    output logic         flag_z,
    output logic         flag_n,
    output logic         flag_c,
    output logic         flag_v,
    output logic         cmp_o
);

    localparam int MSB = W - 1;

    logic [W-1:0] b_eff;
    logic [W:0]   cy;
    flags_t       flg;

    // Conditional inversion of B, one XOR per column
    for (genvar i = 0; i < W; i++) begin : g_binv
        assign b_eff[i] = op_b[i] ^ sub_en;
    end

    addsub_ripple #(.W(W)) u_chain (
        .a_in (op_a),
        .b_in (b_eff),
        .cin  (sub_en),
        .sum  (sum_o),
        .cy   (cy)
    );

    addsub_flags #(.W(W)) u_flags (
        .sum      (sum_o),
        .c_msb_in (cy[MSB]),
        .c_out    (cy[W]),
        .flg      (flg)
    );

    addsub_cond u_cond (
        .flg (flg),
        .sel (cc_sel),
        .hit (cmp_o)
    );

    assign flag_z = flg.z;
    assign flag_n = flg.n;
    assign flag_c = flg.c;
    assign flag_v = flg.v;

endmodule

// File: rtl/addsub_cmp_chk.sv
module addsub_cmp_chk
    import addsub_pkg::*;
#(
    parameter int W = 8
) (
    input logic [W-1:0] op_a,
    input logic [W-1:0] op_b,
    input logic         sub_en,
    input logic [3:0]   cc_sel,
    input logic [W-1:0] sum_o,
    input logic         flag_z,
    input logic         flag_n,
    input logic         flag_c,
    input logic         flag_v,
    input logic         cmp_o
);

    logic [W:0]   wide;
    logic [W-1:0] bx;
    logic         known;

    always_comb begin
        known = !$isunknown({op_a, op_b, sub_en, cc_sel});
        bx    = op_b ^ {W{sub_en}};
        wide  = {1'b0, op_a} + {1'b0, bx} + {{W{1'b0}}, sub_en};
        if (known) begin
            // R1
            add_result_chk: assert (sub_en || sum_o == W'(op_a + op_b));
            // R2
            sub_result_chk: assert (!sub_en || sum_o == W'(op_a - op_b));
            // R3
            sub_zero_chk: assert (!sub_en || flag_z == (op_a == op_b));
            // R5
            carry_out_chk: assert (flag_c == wide[W]);
            // R6
            no_overflow_chk: assert (flag_v == ((op_a[W-1] == bx[W-1]) && (sum_o[W-1] != op_a[W-1])));
            // R8
            geu_cmp_chk: assert (!(sub_en && cc_sel == CC_GEU) || cmp_o == (op_a >= op_b));
            // R9
            unused_code_chk: assert (cc_sel < 4'd10 || !cmp_o);
        end
    end

endmodule

bind addsub_cmp addsub_cmp_chk #(.W(W)) u_chk (
    .op_a   (op_a),
    .op_b   (op_b),
    .sub_en (sub_en),
    .cc_sel (cc_sel),
    .sum_o  (sum_o),
    .flag_z (flag_z),
    .flag_n (flag_n),
    .flag_c (flag_c),
    .flag_v (flag_v),
    .cmp_o  (cmp_o)
);

// File: tb/addsub_cmp_bench.sv
module addsub_cmp_bench;

    localparam int W        = 8;
    localparam int CLK_PER  = 10;
    localparam int WDOG_CYC = 100000;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [W-1:0] op_a = '0;
    logic [W-1:0] op_b = '0;
    logic         sub_en = 1'b0;
    logic [3:0]   cc_sel = 4'd0;
    logic [W-1:0] sum_o;
    logic         flag_z, flag_n, flag_c, flag_v, cmp_o;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    always #(CLK_PER/2) clk = ~clk;

    addsub_cmp #(.W(W)) u_addsub_cmp (
        .op_a   (op_a),
        .op_b   (op_b),
        .sub_en (sub_en),
        .cc_sel (cc_sel),
        .sum_o  (sum_o),
        .flag_z (flag_z),
        .flag_n (flag_n),
        .flag_c (flag_c),
        .flag_v (flag_v),
        .cmp_o  (cmp_o)
    );

    localparam logic [W-1:0] V_ZERO = '0;
    localparam logic [W-1:0] V_ONE  = W'(1);
    localparam logic [W-1:0] V_ALL1 = '1;
    localparam logic [W-1:0] V_MAXP = {1'b0, {(W-1){1'b1}}};
    localparam logic [W-1:0] V_MINN = {1'b1, {(W-1){1'b0}}};

    task automatic chk(input string req, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h (a=%0h b=%0h sub=%0b cc=%0d)",
                     req, act, exp, op_a, op_b, sub_en, cc_sel);
        end
    endtask

    task automatic drive(input logic [W-1:0] a, input logic [W-1:0] b,
                         input logic s, input logic [3:0] cc);
        @(posedge clk);
        op_a = a; op_b = b; sub_en = s; cc_sel = cc;
        @(negedge clk);
    endtask

    // Reference model for the arithmetic outputs
    task automatic check_arith(input logic [W-1:0] a, input logic [W-1:0] b, input logic s);
        longint ua, ub, ures, sres, sa, sb;
        logic [W-1:0] exp_sum;
        drive(a, b, s, 4'd15);
        ua = longint'(a);
        ub = longint'(b);
        sa = longint'($signed(a));
        sb = longint'($signed(b));
        ures = s ? (ua + ((1 << W) - 1 - ub) + 1) : (ua + ub);
        sres = s ? (sa - sb) : (sa + sb);
        exp_sum = W'(ures);
        if (s) chk("R2 difference", sum_o, exp_sum);
        else   chk("R1 sum", sum_o, exp_sum);
        chk("R3 zero flag", flag_z, exp_sum == '0);
        chk("R4 negative flag", flag_n, exp_sum[W-1]);
        chk("R5 carry flag", flag_c, (ures >> W) & 1);
        if (s) chk("R5 no-borrow relation", flag_c, ua >= ub);
        chk("R6 overflow flag", flag_v,
            (sres > (longint'(1) << (W-1)) - 1) || (sres < -(longint'(1) << (W-1))));
        chk("R9 unused code", cmp_o, 0);
    endtask

    task automatic check_cmp(input logic [W-1:0] a, input logic [W-1:0] b);
        longint sa, sb, ua, ub;
        sa = longint'($signed(a));
        sb = longint'($signed(b));
        ua = longint'(a);
        ub = longint'(b);
        for (int cc = 0; cc < 16; cc++) begin
            logic e;
            drive(a, b, 1'b1, 4'(cc));
            case (cc)
                0: e = (sa == sb);
                1: e = (sa != sb);
                2: e = (sa <  sb);
                3: e = (sa <= sb);
                4: e = (sa >  sb);
                5: e = (sa >= sb);
                6: e = (ua <  ub);
                7: e = (ua <= ub);
                8: e = (ua >  ub);
                9: e = (ua >= ub);
                default: e = 1'b0;
            endcase
            if (cc < 6)       chk("R7 signed relation", cmp_o, e);
            else if (cc < 10) chk("R8 unsigned relation", cmp_o, e);
            else              chk("R9 unused code", cmp_o, e);
        end
    endtask

    task automatic t_reset_state;
        repeat (3) @(posedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 idle sum", sum_o, 0);
        chk("R3 idle zero", flag_z, 1);
        chk("R5 idle carry", flag_c, 0);
        chk("R7 idle EQ", cmp_o, 1);
    endtask

    task automatic t_chain;
        drive(V_ALL1, V_ONE, 1'b0, 4'd15);
        chk("R10 chain sum", sum_o, 0);
        chk("R10 chain carry", flag_c, 1);
        chk("R10 chain zero", flag_z, 1);
        chk("R10 chain overflow", flag_v, 0);
    endtask

    task automatic t_overflow_edges;
        drive(V_MAXP, V_ONE, 1'b0, 4'd15);
        chk("R6 max+1 overflow", flag_v, 1);
        chk("R4 max+1 sign", flag_n, 1);
        drive(V_MINN, V_ONE, 1'b1, 4'd15);
        chk("R6 min-1 overflow", flag_v, 1);
        chk("R2 min-1 value", sum_o, V_MAXP);
        drive(V_ZERO, V_MINN, 1'b1, 4'd15);
        chk("R6 0-min overflow", flag_v, 1);
        drive(V_ALL1, V_MINN, 1'b1, 4'd15);
        chk("R6 -1-min no overflow", flag_v, 0);
    endtask

    task automatic t_corner_grid;
        logic [W-1:0] vals [5];
        vals[0] = V_ZERO; vals[1] = V_ONE; vals[2] = V_ALL1;
        vals[3] = V_MAXP; vals[4] = V_MINN;
        for (int i = 0; i < 5; i++)
            for (int j = 0; j < 5; j++) begin
                check_arith(vals[i], vals[j], 1'b0);
                check_arith(vals[i], vals[j], 1'b1);
                check_cmp(vals[i], vals[j]);
            end
    endtask

    task automatic t_random;
        for (int k = 0; k < 300; k++) begin
            logic [W-1:0] a, b;
            a = W'($urandom);
            b = W'($urandom);
            check_arith(a, b, k[0]);
            if (k % 10 == 0) check_cmp(a, b);
        end
    endtask

    initial begin
        repeat (WDOG_CYC) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        t_reset_state();
        t_chain();
        t_overflow_edges();
        t_corner_grid();
        t_random();
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule